// File: doc/BRIEF.md
# Programmable-Polynomial CRC Division Engine

This block reduces a packet of bytes modulo a generator polynomial that is chosen at run time. Subtraction is a bitwise XOR with no carries or borrows. The quotient is never kept. Only the final remainder comes out, as a 32-bit word, together with a one-cycle done pulse. A sender appends that remainder to its packet. A receiver runs the same division with the same polynomial and compares the two remainders.

The polynomial is given in full form, with its leading one included. Its degree may be anything up to 24. A leading-one position encoder measures the widths of both the running value and the polynomial. The polynomial is then shifted so that its top bit lines up with the top bit of the running value, and one XOR is done per clock.

Bytes arrive most significant first, under a valid/ready handshake. The engine lowers `in_ready` while it reduces each byte.

Top module: `crc_div_engine`

## Requirements
- R1: After reset, `done` is 0, `rem_out` is 0 and `in_ready` is 0. No byte is accepted until a start edge.
- R2: A rising edge on `start` does four things: it samples `poly`, clears the running value, clears `rem_out` to 0, and raises `in_ready` on the following cycle. Holding `start` high does not restart the engine again.
- R3: With polynomial 0x1B (binary 11011) and the bytes 0x0E then 0x50, the remainder is 0x4.
- R4: Bytes enter most significant first. The result equals the concatenation of all bytes, read as one binary polynomial, reduced modulo the polynomial.
- R5: The polynomial includes its top bit (CCITT is given as 0x11021), and degrees up to 24 are handled. The remainder is the full 32-bit word, and bits 31..24 of it are always 0.
- R6: Each XOR reduction takes exactly one clock. A byte that needs k reductions keeps `in_ready` low for k+1 cycles after the cycle in which it was accepted.
- R7: `done` is high for exactly one cycle, in the cycle after the last byte's reduction ends. `rem_out` updates in that same cycle and then holds until the next start edge.
- R8: A byte offered while `in_ready` is low has no effect on the result. This covers both the idle state and the cycles spent reducing.
- R9: Changing `poly` after the start edge has no effect on the packet already in progress.
- R10: Data that is an exact multiple of the polynomial gives a remainder of 0.
- R11: A start edge in the middle of a packet abandons it. The new packet's result is unaffected by the abandoned bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Rising edge begins a new packet |
| poly | input | 32 | Generator polynomial, full form, sampled at start |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Packet byte, most significant first |
| in_last | input | 1 | Marks the final byte of the packet |
| in_ready | output | 1 | Engine can take a byte this cycle |
| rem_out | output | 32 | Remainder of the last finished packet |
| done | output | 1 | One-cycle pulse when `rem_out` is updated |

## Verification
The engine is first tried with the small worked example, then with the same two bytes swapped, which shows whether byte order is respected. A 16-bit and a 24-bit polynomial over multi-byte packets expose any truncation of wide remainders. Single bytes that need zero or one reduction pin down the exact cycle latency. A packet that is an exact multiple of the polynomial must give zero. Stray bytes offered while busy or idle, a polynomial change during a packet, a held start and a restart in mid-packet each show whether state leaks from one operation into the next.

// File: rtl/crc_div_pkg.sv
package crc_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TAKE   = 2'd1,
    ST_REDUCE = 2'd2
  } crc_state_e;

endpackage

// File: rtl/lead_one_pos.sv
module lead_one_pos #(
  parameter int W  = 32,
  parameter int PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [PW-1:0] width
);

  // Later (higher) bits overwrite earlier ones, giving priority to the top set bit.
  always_comb begin
    width = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) width = PW'(i + 1);
    end
  end

endmodule

// File: rtl/crc_reduce_step.sv
module crc_reduce_step #(
  parameter int W  = 32,
  parameter int PW = $clog2(W + 1)
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] poly,
  output logic         need,
  output logic [W-1:0] nxt
);

  logic [PW-1:0] w_acc;
  logic [PW-1:0] w_poly;
  logic [PW-1:0] shamt;

  lead_one_pos #(.W(W), .PW(PW)) u_acc_pos (
    .val   (acc),
    .width (w_acc)
  );

  lead_one_pos #(.W(W), .PW(PW)) u_poly_pos (
    .val   (poly),
    .width (w_poly)
  );

  always_comb begin
    need  = (w_poly != '0) && (w_acc >= w_poly);
    shamt = w_acc - w_poly;
    nxt   = acc ^ (poly << shamt);
  end

endmodule

// File: rtl/crc_div_ctrl.sv
module crc_div_ctrl
  import crc_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_rise,
  input  logic in_valid,
  input  logic in_last,
  input  logic need,
  output logic in_ready,
  output logic take,
  output logic do_xor,
  output logic fin
);

  crc_state_e state_q, state_d;
  logic       last_q;

  always_comb begin
    in_ready = (state_q == ST_TAKE);
    take     = in_ready && in_valid && !start_rise;
    do_xor   = (state_q == ST_REDUCE) && need && !start_rise;
    fin      = (state_q == ST_REDUCE) && !need && last_q && !start_rise;
    state_d  = state_q;
    if (start_rise) begin
      state_d = ST_TAKE;
    end else begin
      case (state_q)
        ST_TAKE:   if (in_valid) state_d = ST_REDUCE;
        ST_REDUCE: if (!need) state_d = last_q ? ST_IDLE : ST_TAKE;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) last_q <= in_last;
    end
  end

endmodule

// File: rtl/crc_div_engine.sv
module crc_div_engine #(
  parameter int ACC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ACC_W-1:0]  poly,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [ACC_W-1:0]  rem_out,
  output logic              done
);

  localparam int PW = $clog2(ACC_W + 1);

  logic             start_q;
  logic             start_rise;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] poly_q;
  logic [ACC_W-1:0] acc_nxt;
  logic             need;
  logic             take;
  logic             do_xor;
  logic             fin;

  assign start_rise = start && !start_q;

  crc_reduce_step #(.W(ACC_W), .PW(PW)) u_step (
    .acc  (acc_q),
    .poly (poly_q),
    .need (need),
    .nxt  (acc_nxt)
  );

  crc_div_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_rise (start_rise),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .need       (need),
    .in_ready   (in_ready),
    .take       (take),
    .do_xor     (do_xor),
    .fin        (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      acc_q   <= '0;
      poly_q  <= '0;
      rem_out <= '0;
      done    <= 1'b0;
    end else begin
      start_q <= start;
      done    <= fin;
      if (start_rise) begin
        acc_q   <= '0;
        poly_q  <= poly;
        rem_out <= '0;
      end else begin
        if (take)        acc_q   <= {acc_q[ACC_W-BYTE_W-1:0], in_data};
        else if (do_xor) acc_q   <= acc_nxt;
        if (fin)         rem_out <= acc_q;
      end
    end
  end

endmodule

// File: rtl/crc_div_chk.sv
module crc_div_chk #(
  parameter int ACC_W  = 32,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [ACC_W-1:0] rem_out
);

  logic s_q;
  logic s_rise;

  always_ff @(posedge clk) begin
    if (rst) s_q <= 1'b0;
    else     s_q <= start;
  end
  assign s_rise = start && !s_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    s_rise |=> (in_ready && rem_out == '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_REM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rem_out != $past(rem_out)) |-> (done || $past(start))); // R7
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready); // R7
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !s_rise) |=> !in_ready); // R6
  AST_REM_DEGREE: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_out[ACC_W-1:ACC_W-BYTE_W] == '0)); // R5

endmodule

bind crc_div_engine crc_div_chk #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .rem_out  (rem_out)
);

// File: tb/crc_div_engine_bench.sv
module crc_div_engine_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] poly = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [31:0] rem_out;
  logic        done;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_div_engine u_crc_div_engine (
    .clk(clk), .rst(rst), .start(start), .poly(poly),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .rem_out(rem_out), .done(done)
  );

  function automatic int bw(longint v);
    int w = 0;
    for (int i = 0; i < 48; i++) if (v[i]) w = i + 1;
    return w;
  endfunction

  function automatic longint pmod(longint v, longint p);
    int wp = bw(p);
    if (wp == 0) return v;
    while (bw(v) >= wp) v = v ^ (p << (bw(v) - wp));
    return v;
  endfunction

  function automatic int nsteps(longint v, longint p);
    int n = 0;
    int wp = bw(p);
    if (wp == 0) return 0;
    while (bw(v) >= wp) begin v = v ^ (p << (bw(v) - wp)); n++; end
    return n;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  int     m_state, m_cnt;
  longint m_acc, m_rem, m_poly;
  bit     m_done, m_prev, m_last;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cnt = 0; m_acc = 0; m_rem = 0; m_poly = 0;
      m_done = 0; m_prev = 0; m_last = 0;
    end else begin
      m_done = 0;
      if (start && !m_prev) begin
        m_state = 1; m_acc = 0; m_rem = 0; m_poly = poly;
      end else if (m_state == 1) begin
        if (in_valid) begin
          m_acc = ((m_acc << 8) | in_data) & 64'hFFFF_FFFF;
          m_cnt = nsteps(m_acc, m_poly);
          m_last = in_last;
          m_state = 2;
        end
      end else if (m_state == 2) begin
        if (m_cnt > 0) m_cnt--;
        else begin
          m_acc = pmod(m_acc, m_poly);
          if (m_last) begin m_done = 1; m_rem = m_acc; m_state = 0; end
          else m_state = 1;
        end
      end
      m_prev = start;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(in_ready === (m_state == 1), "R6 in_ready vs model", in_ready, m_state == 1);
      chk(done === m_done, "R7 done vs model", done, m_done);
      chk(rem_out === m_rem[31:0], "R4 rem_out vs model", rem_out, m_rem);
    end
  end

  task automatic do_start(logic [31:0] p);
    @(negedge clk); start = 1'b1; poly = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, bit last);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    longint exp;
    byte    msg [9];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 0, "R1 done", done, 0);
    chk(rem_out == 0, "R1 rem_out", rem_out, 0);
    chk(in_ready == 0, "R1 in_ready", in_ready, 0);

    // R3 worked example
    do_start(32'h1B);
    send_byte(8'h0E, 0); send_byte(8'h50, 1); wait_done();
    chk(rem_out == 32'h4, "R3 worked example", rem_out, 4);
    @(negedge clk);
    chk(done == 0, "R7 done single cycle", done, 0);
    repeat (5) @(negedge clk);
    chk(rem_out == 32'h4, "R7 remainder held", rem_out, 4);

    // R8 bytes offered while idle are ignored
    in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(done == 0 && rem_out == 32'h4, "R8 idle byte ignored", rem_out, 4);

    // R4 swapped byte order
    do_start(32'h1B);
    chk(rem_out == 0, "R2 start clears rem_out", rem_out, 0);
    chk(in_ready == 1, "R2 ready after start", in_ready, 1);
    send_byte(8'h50, 0); send_byte(8'h0E, 1); wait_done();
    exp = pmod(64'h500E, 64'h1B);
    chk(rem_out == exp[31:0], "R4 msb-first order", rem_out, exp);

    // R5 CCITT in full form over nine ASCII digits
    for (int i = 0; i < 9; i++) msg[i] = byte'(8'h31 + i);
    do_start(32'h11021);
    exp = 0;
    for (int i = 0; i < 9; i++) begin
      send_byte(msg[i], i == 8);
      exp = pmod((exp << 8) | msg[i], 64'h11021);
    end
    wait_done();
    chk(rem_out == exp[31:0], "R5 16-bit polynomial", rem_out, exp);
    chk(rem_out < 32'h10000, "R5 16-bit remainder range", rem_out, exp);

    // R5 degree-24 polynomial
    do_start(32'h0186_4CFB);
    exp = 0;
    for (int i = 0; i < 6; i++) begin
      send_byte(8'hF0 ^ 8'(i * 37), i == 5);
      exp = pmod((exp << 8) | (8'hF0 ^ 8'(i * 37)), 64'h0186_4CFB);
    end
    wait_done();
    chk(rem_out == exp[31:0], "R5 24-degree polynomial", rem_out, exp);

    // R10 exact multiple gives zero
    do_start(32'h1B);
    send_byte(8'h00, 0); send_byte(8'h1B, 1); wait_done();
    chk(rem_out == 0, "R10 exact multiple", rem_out, 0);

    // R6 latency: no reduction
    do_start(32'h1B);
    send_byte(8'h0A, 1);
    @(negedge clk);
    chk(done == 1 && rem_out == 32'hA, "R6 zero-step latency", rem_out, 32'hA);

    // R6 latency: one reduction
    do_start(32'h1B);
    send_byte(8'h1B, 1);
    @(negedge clk);
    chk(done == 0, "R6 one-step not yet done", done, 0);
    @(negedge clk);
    chk(done == 1 && rem_out == 0, "R6 one-step latency", done, 1);

    // R8 byte offered while reducing is ignored
    do_start(32'h1B);
    send_byte(8'hFF, 0);
    in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    send_byte(8'h50, 1); wait_done();
    exp = pmod(64'hFF50, 64'h1B);
    chk(rem_out == exp[31:0], "R8 busy byte ignored", rem_out, exp);

    // R9 polynomial change mid-packet ignored
    do_start(32'h1B);
    poly = 32'h13;
    send_byte(8'h0E, 0); send_byte(8'h50, 1); wait_done();
    chk(rem_out == 32'h4, "R9 poly sampled at start", rem_out, 4);

    // R2 held start does not restart
    @(negedge clk); start = 1'b1; poly = 32'h1B;
    send_byte(8'h0E, 0); send_byte(8'h50, 1); wait_done();
    chk(rem_out == 32'h4, "R2 held start single edge", rem_out, 4);
    start = 1'b0;

    // R11 restart mid-packet
    do_start(32'h1B);
    send_byte(8'h12, 0);
    do_start(32'h1B);
    send_byte(8'h0E, 0); send_byte(8'h50, 1); wait_done();
    chk(rem_out == 32'h4, "R11 restart discards bytes", rem_out, 4);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule